// File: doc/BRIEF.md
# Bus Driver Fault Supervisor

This block supervises the output drivers of a multi-channel differential bus master. Each channel receives digital flags from the analog front end: a sourcing over-current flag, a sinking over-current flag, an idle double-current-limit flag and a thermal fault flag. From these and the bus frame timing, it decides whether the channel's driver pair may be enabled. It also keeps the fault bits that a host reads back.

During signaling, a short over-current event is tolerated only for a filtered interval. If the current stays high past that interval, the channel's drivers are released to high impedance for the rest of the frame. They retry at the next frame. If a channel trips in two back-to-back frames, it is switched off until the host turns it on again. A thermal fault switches the channel off at once. Channel 0 also owns the enable of an auxiliary bus switch, which follows that channel's host enable and its persistent shutdown.

The bus phase is a level input `bus_sig` (1 = signaling, 0 = idle). A transaction starts on the first cycle in which `bus_sig` is seen high after being low. `frame_end` is a one-cycle pulse that closes a frame. Host writes to the channel enable bits are given by a per-channel strobe and a data bit. All outputs are registered and change on the clock edge that samples the cause.

Top module: `bus_fault_supervisor`

## Requirements
- R1: The sourcing and sinking flags of a channel are ORed. While the channel is enabled, signaling and not already shut down, a shutdown trips on the clock edge that samples that OR high for the FILT_LEN-th consecutive time. A low sample restarts the count.
- R2: A trip drives the channel's `drv_en` bit to 0 and sets its `stat_sds` bit on that same edge. Over-current flags sampled while `bus_sig` is 0 never trip.
- R3: After a trip, `drv_en` stays 0 for the rest of the frame. The edge that samples `frame_end` restores `drv_en` to 1 if the channel is still enabled.
- R4: A trip in a frame that directly follows a frame with a trip clears `en_bit` and sets `isd_bit` on the trip edge. A frame with no trip in between prevents this.
- R5: When channel 0 enters the persistent shutdown, `aux_sw_en` goes to 0 on the same edge. A persistent shutdown of any other channel leaves `aux_sw_en` unchanged.
- R6: If `idle_ilim` is sampled high for an enabled channel while `bus_sig` is 0, `stat_icl` is 1 from the next transaction start. At each later transaction start, it reloads what was seen during the idle period before it.
- R7: A sampled `therm_flt` bit clears `en_bit` and `drv_en` and sets `otf_bit` on that edge. The channel stays off after the flag drops, until a host enable write.
- R8: A host write with data 1 sets `en_bit` and clears `isd_bit` and `otf_bit`, but it is ignored while that channel's `therm_flt` is high. A write with data 0 clears `en_bit` and `drv_en`.
- R9: A synchronous active-high `rst` clears every output to 0, so all drivers are off.
- R10: `stat_sds` is cleared at the start of the next transaction.
- R11: An accepted channel-0 enable write sets `aux_sw_en`. A channel-0 disable write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sig | input | 1 | Bus phase: 1 signaling, 0 idle |
| frame_end | input | 1 | One-cycle end-of-frame pulse |
| src_oc | input | N_CH | Sourcing over-current flags |
| snk_oc | input | N_CH | Sinking over-current flags |
| idle_ilim | input | N_CH | Idle double-current-limit flags |
| therm_flt | input | N_CH | Thermal fault flags |
| en_wr | input | N_CH | Host enable write strobes |
| en_wdata | input | N_CH | Host enable write data |
| drv_en | output | N_CH | Driver pair enable per channel |
| en_bit | output | N_CH | Channel enable register bit |
| isd_bit | output | N_CH | Persistent shutdown bit |
| otf_bit | output | N_CH | Thermal fault bit |
| stat_sds | output | N_CH | Signal-driver shutdown status bit |
| stat_icl | output | N_CH | Idle current-limit status bit |
| aux_sw_en | output | 1 | Auxiliary bus switch enable (channel 0) |

## Verification
The hardest situation to reach is the persistent shutdown. It needs two trips in frames with no clean frame between them. It also needs a second sequence in which one clean frame separates two trips and no latch results. The stimulus builds these frame by frame with explicit frame-start and frame-end steps. It holds the ORed flags for exactly FILT_LEN cycles, switching between source and sink inside the window. The consecutive-frame memory therefore shows up only through `isd_bit`, `en_bit` and `aux_sw_en`. Channel 1 is taken through its persistent shutdown first, which shows that `aux_sw_en` ignores every channel but 0.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef struct packed {
    logic en;
    logic isd;
    logic otf;
    logic sds;
    logic icl;
  } ch_flags_t;
endpackage

// File: rtl/oc_filter.sv
module oc_filter #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic flag,
  output logic trip
);
  localparam int W = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || !flag) cnt <= '0;
    else if (cnt != LAST)     cnt <= cnt + 1'b1;
  end

  assign trip = run && flag && (cnt == LAST);
endmodule

// File: rtl/ch_supervisor.sv
module ch_supervisor
  import fsup_pkg::*;
#(
  parameter int LEN     = 8,
  parameter bit HAS_AUX = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      src_oc,
  input  logic      snk_oc,
  input  logic      idle_lim,
  input  logic      therm,
  input  logic      bus_sig,
  input  logic      sig_start,
  input  logic      frame_end,
  input  logic      wr,
  input  logic      wdata,
  output logic      drv_en,
  output ch_flags_t flags,
  output logic      aux_en
);
  ch_flags_t fl_q, fl_n;
  logic oc_q, oc_n;
  logic prev_q, prev_n;
  logic iseen_q, iseen_n;
  logic drv_q;
  logic run, trip, wr_on, wr_off, persist;

  assign run = fl_q.en && bus_sig && !oc_q;

  oc_filter #(.LEN(LEN)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .flag (src_oc | snk_oc),
    .trip (trip)
  );

  assign wr_on   = wr && wdata && !therm;
  assign wr_off  = wr && !wdata;
  assign persist = trip && prev_q;

  always_comb begin
    fl_n    = fl_q;
    oc_n    = oc_q;
    prev_n  = prev_q;
    iseen_n = iseen_q;
    if (wr_on) begin
      fl_n.en  = 1'b1;
      fl_n.isd = 1'b0;
      fl_n.otf = 1'b0;
      prev_n   = 1'b0;
    end
    if (wr_off) fl_n.en = 1'b0;
    if (sig_start) begin
      fl_n.sds = 1'b0;
      fl_n.icl = iseen_q;
      iseen_n  = 1'b0;
    end
    if (!bus_sig && fl_q.en && idle_lim) iseen_n = 1'b1;
    if (trip) begin
      oc_n     = 1'b1;
      fl_n.sds = 1'b1;
    end
    if (persist) begin
      fl_n.en  = 1'b0;
      fl_n.isd = 1'b1;
    end
    if (frame_end) begin
      prev_n = oc_q || trip;
      oc_n   = 1'b0;
    end
    if (therm) begin
      fl_n.en  = 1'b0;
      fl_n.otf = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_q    <= '0;
      oc_q    <= 1'b0;
      prev_q  <= 1'b0;
      iseen_q <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      fl_q    <= fl_n;
      oc_q    <= oc_n;
      prev_q  <= prev_n;
      iseen_q <= iseen_n;
      drv_q   <= fl_n.en && !oc_n;
    end
  end

  assign drv_en = drv_q;
  assign flags  = fl_q;

  generate
    if (HAS_AUX) begin : g_aux
      logic aux_q;
      always_ff @(posedge clk) begin
        if (rst)                  aux_q <= 1'b0;
        else if (persist)         aux_q <= 1'b0;
        else if (wr_on)           aux_q <= 1'b1;
        else if (wr_off)          aux_q <= 1'b0;
      end
      assign aux_en = aux_q;
    end else begin : g_noaux
      assign aux_en = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/bus_fault_supervisor.sv
module bus_fault_supervisor
  import fsup_pkg::*;
#(
  parameter int N_CH     = 4,
  parameter int FILT_LEN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sig,
  input  logic            frame_end,
  input  logic [N_CH-1:0] src_oc,
  input  logic [N_CH-1:0] snk_oc,
  input  logic [N_CH-1:0] idle_ilim,
  input  logic [N_CH-1:0] therm_flt,
  input  logic [N_CH-1:0] en_wr,
  input  logic [N_CH-1:0] en_wdata,
  output logic [N_CH-1:0] drv_en,
  output logic [N_CH-1:0] en_bit,
  output logic [N_CH-1:0] isd_bit,
  output logic [N_CH-1:0] otf_bit,
  output logic [N_CH-1:0] stat_sds,
  output logic [N_CH-1:0] stat_icl,
  output logic            aux_sw_en
);
  logic sig_d;
  logic sig_start;
  logic [N_CH-1:0] aux_v;

  always_ff @(posedge clk) begin
    if (rst) sig_d <= 1'b0;
    else     sig_d <= bus_sig;
  end

  assign sig_start = bus_sig && !sig_d;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ch_flags_t fl;
    ch_supervisor #(.LEN(FILT_LEN), .HAS_AUX(c == 0)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .src_oc    (src_oc[c]),
      .snk_oc    (snk_oc[c]),
      .idle_lim  (idle_ilim[c]),
      .therm     (therm_flt[c]),
      .bus_sig   (bus_sig),
      .sig_start (sig_start),
      .frame_end (frame_end),
      .wr        (en_wr[c]),
      .wdata     (en_wdata[c]),
      .drv_en    (drv_en[c]),
      .flags     (fl),
      .aux_en    (aux_v[c])
    );
    assign en_bit[c]   = fl.en;
    assign isd_bit[c]  = fl.isd;
    assign otf_bit[c]  = fl.otf;
    assign stat_sds[c] = fl.sds;
    assign stat_icl[c] = fl.icl;
  end

  assign aux_sw_en = aux_v[0];
endmodule

// File: rtl/bus_fault_supervisor_chk.sv
module bus_fault_supervisor_chk #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_sig,
  input logic [N_CH-1:0] therm_flt,
  input logic [N_CH-1:0] en_wr,
  input logic [N_CH-1:0] en_wdata,
  input logic [N_CH-1:0] drv_en,
  input logic [N_CH-1:0] en_bit,
  input logic [N_CH-1:0] isd_bit,
  input logic [N_CH-1:0] otf_bit,
  input logic [N_CH-1:0] stat_sds,
  input logic            aux_sw_en
);
  for (genvar c = 0; c < N_CH; c++) begin : g_a
    assert_sds_in_sig_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(stat_sds[c]) |-> $past(bus_sig));
    assert_isd_disables_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(isd_bit[c]) |-> (!en_bit[c] && !drv_en[c]));
    assert_therm_off_R7: assert property (@(posedge clk) disable iff (rst)
      therm_flt[c] |=> (!en_bit[c] && !drv_en[c] && otf_bit[c]));
    assert_wr_blocked_R8: assert property (@(posedge clk) disable iff (rst)
      (en_wr[c] && en_wdata[c] && therm_flt[c]) |=> !en_bit[c]);
  end

  assert_aux_off_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(isd_bit[0]) |-> !aux_sw_en);

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (drv_en == '0 && en_bit == '0 && aux_sw_en == 1'b0));
endmodule

bind bus_fault_supervisor bus_fault_supervisor_chk #(.N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sig   (bus_sig),
  .therm_flt (therm_flt),
  .en_wr     (en_wr),
  .en_wdata  (en_wdata),
  .drv_en    (drv_en),
  .en_bit    (en_bit),
  .isd_bit   (isd_bit),
  .otf_bit   (otf_bit),
  .stat_sds  (stat_sds),
  .aux_sw_en (aux_sw_en)
);

// File: tb/bus_fault_supervisor_test.sv
`timescale 1ns/1ps
module bus_fault_supervisor_test;
  localparam int N = 2;
  localparam int FL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sig = 1'b0, frame_end = 1'b0;
  logic [N-1:0] src_oc = '0, snk_oc = '0, idle_ilim = '0, therm_flt = '0;
  logic [N-1:0] en_wr = '0, en_wdata = '0;
  logic [N-1:0] drv_en, en_bit, isd_bit, otf_bit, stat_sds, stat_icl;
  logic aux_sw_en;
  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;

  bus_fault_supervisor #(.N_CH(N), .FILT_LEN(FL)) uut (
    .clk(clk), .rst(rst), .bus_sig(bus_sig), .frame_end(frame_end),
    .src_oc(src_oc), .snk_oc(snk_oc), .idle_ilim(idle_ilim),
    .therm_flt(therm_flt), .en_wr(en_wr), .en_wdata(en_wdata),
    .drv_en(drv_en), .en_bit(en_bit), .isd_bit(isd_bit), .otf_bit(otf_bit),
    .stat_sds(stat_sds), .stat_icl(stat_icl), .aux_sw_en(aux_sw_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input int ch, input logic val);
    en_wr[ch] = 1'b1;
    en_wdata[ch] = val;
    step();
    en_wr = '0;
    en_wdata = '0;
  endtask

  task automatic frame_begin();
    bus_sig = 1'b1;
    step();
  endtask

  task automatic frame_finish();
    frame_end = 1'b1;
    step();
    frame_end = 1'b0;
    bus_sig = 1'b0;
    step();
  endtask

  task automatic trip_ch(input int ch);
    snk_oc[ch] = 1'b1;
    step(FL);
    snk_oc[ch] = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step();
    check("R9 drv_en", drv_en, 0);
    check("R9 en_bit", en_bit, 0);
    check("R9 aux", aux_sw_en, 0);
  endtask

  task automatic t_enable();
    host_write(0, 1'b1);
    host_write(1, 1'b1);
    check("R8 en_bit on", en_bit, 2'b11);
    check("R8 drv_en on", drv_en, 2'b11);
    check("R11 aux set", aux_sw_en, 1);
  endtask

  task automatic t_ch1_persist();
    frame_begin();
    trip_ch(1);
    check("R2 ch1 trip drv", drv_en, 2'b01);
    frame_finish();
    check("R3 ch1 retry", drv_en, 2'b11);
    frame_begin();
    trip_ch(1);
    check("R4 ch1 isd", isd_bit, 2'b10);
    check("R4 ch1 en cleared", en_bit, 2'b01);
    check("R5 aux kept for ch1", aux_sw_en, 1);
    frame_finish();
    check("R4 ch1 stays off", drv_en, 2'b01);
  endtask

  task automatic t_filter_ch0();
    frame_begin();
    check("R10 sds cleared", stat_sds[0], 0);
    src_oc[0] = 1'b1;
    step(FL - 1);
    check("R1 no trip before count", drv_en[0], 1);
    src_oc[0] = 1'b0;
    step();
    snk_oc[0] = 1'b1;
    step();
    src_oc[0] = 1'b1;
    step();
    snk_oc[0] = 1'b0;
    step(FL - 3);
    check("R1 gap restarts count", drv_en[0], 1);
    step();
    src_oc[0] = 1'b0;
    check("R1 OR trip", drv_en[0], 0);
    check("R2 sds set", stat_sds[0], 1);
    step(3);
    check("R3 off in frame", drv_en[0], 0);
    frame_finish();
    check("R3 on after frame end", drv_en[0], 1);
  endtask

  task automatic t_idle_no_trip();
    src_oc[0] = 1'b1;
    step(FL * 2);
    src_oc[0] = 1'b0;
    check("R2 idle no trip", drv_en[0], 1);
    check("R2 idle sds held", stat_sds[0], 1);
  endtask

  task automatic t_nonconsec_then_persist();
    frame_begin();
    check("R10 sds cleared start", stat_sds[0], 0);
    frame_finish();
    frame_begin();
    trip_ch(0);
    check("R2 ch0 trip", drv_en[0], 0);
    frame_finish();
    check("R4 clean gap no latch en", en_bit[0], 1);
    check("R4 clean gap no isd", isd_bit[0], 0);
    frame_begin();
    trip_ch(0);
    check("R4 ch0 isd", isd_bit[0], 1);
    check("R4 ch0 en off", en_bit[0], 0);
    check("R5 aux off", aux_sw_en, 0);
    frame_finish();
    check("R4 ch0 stays off", drv_en[0], 0);
  endtask

  task automatic t_reenable();
    host_write(0, 1'b1);
    check("R8 isd cleared", isd_bit[0], 0);
    check("R8 en restored", en_bit[0], 1);
    check("R11 aux back", aux_sw_en, 1);
    host_write(0, 1'b0);
    check("R8 write0 drv", drv_en[0], 0);
    check("R11 aux write0", aux_sw_en, 0);
    host_write(0, 1'b1);
  endtask

  task automatic t_icl();
    idle_ilim[0] = 1'b1;
    step();
    idle_ilim[0] = 1'b0;
    check("R6 icl not yet", stat_icl[0], 0);
    frame_begin();
    check("R6 icl loaded", stat_icl[0], 1);
    frame_finish();
    frame_begin();
    check("R6 icl reloaded clear", stat_icl[0], 0);
    frame_finish();
  endtask

  task automatic t_thermal();
    host_write(1, 1'b1);
    check("R8 ch1 re-enable", en_bit[1], 1);
    therm_flt[1] = 1'b1;
    step();
    check("R7 therm drv", drv_en[1], 0);
    check("R7 therm en", en_bit[1], 0);
    check("R7 therm otf", otf_bit[1], 1);
    host_write(1, 1'b1);
    check("R8 write ignored in fault", en_bit[1], 0);
    therm_flt[1] = 1'b0;
    step(3);
    check("R7 stays off", drv_en[1], 0);
    host_write(1, 1'b1);
    check("R8 otf cleared", otf_bit[1], 0);
    check("R8 drv back", drv_en[1], 1);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_ch1_persist();
    t_filter_ch0();
    t_idle_no_trip();
    t_nonconsec_then_persist();
    t_reenable();
    t_icl();
    t_thermal();
    t_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule